// File: doc/BRIEF.md
# Scanline-Counting Interrupt Generator

This block raises an interrupt to the CPU after a programmed number of visible, rendered scanlines. The cartridge address decoder forwards CPU register writes to it. The picture side supplies three inputs: a one-cycle strobe per scanline, the number of that line, and a flag that says whether rendering is on. The block holds a reload latch, a down-counter, an enable bit, a pending-reload flag and a direct-load flag. Its single output is an active-high level interrupt that stays up until software acknowledges it.

Unlike an auto-reloading scanline counter, this counter stops at zero and stays there until software loads it again. There are three ways to load it: an explicit reload command, a latch write that arrives in the same scanline as a disable, or an enable issued while a latch value is still pending. When a register write and a scanline strobe fall in the same clock cycle, the strobe is handled first and the write is applied on top of its result.

Top module: `scanline_irq_gen`

## Requirements
- R1: Reset clears the interrupt, counter, latch, enable, pending flag and direct-load flag. After reset, enabling and then counting any number of scanlines raises no interrupt.
- R2: A write to the latch register (masked address 0xC000), when the direct-load flag is clear, stores the data in the latch and sets the pending flag. The counter is left unchanged.
- R3: A latch-register write made while the direct-load flag is set also loads the data straight into the counter and clears the pending flag. A later enable then does not reload the counter.
- R4: A write to the reload register (masked address 0xC001) copies the latch into the counter.
- R5: A write to the disable register (masked address 0xE000) clears enable, drops the interrupt on the next clock and sets the direct-load flag.
- R6: A write to the enable register (masked address 0xE001) sets enable. If the pending flag is set, the same write also loads the counter from the latch.
- R7: A scanline strobe decrements a nonzero counter by one, but only when the line number is between 0 and 239 inclusive and rendering is on. A counter at zero stays at zero, and strobes outside those conditions leave the counter unchanged.
- R8: The interrupt asserts on the clock after a decrement takes the counter from 1 to 0 while enable is set. It never asserts if enable is clear at that decrement.
- R9: Every scanline strobe clears the direct-load flag, whatever the line number or rendering state.
- R10: Once asserted, the interrupt stays high through reloads, enables and further strobes until a disable write or a reset.
- R11: When a write and a strobe arrive in the same cycle, the strobe's effect (decrement, interrupt set, direct-load clear) is applied first and the write's effect is applied after it.
- R12: The register is chosen by the write address ANDed with 0xE001. Writes whose masked address matches none of the four registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe from the cartridge decoder |
| wr_addr | input | ADDR_W (16) | CPU write address |
| wr_data | input | DATA_W (8) | CPU write data |
| line_strobe | input | 1 | One-cycle pulse at each scanline boundary |
| line_num | input | LINE_W (9) | Number of the scanline being signalled |
| render_on | input | 1 | Rendering enabled flag |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The bench targets the loads that depend on history. A design that kept the direct-load flag across a strobe would load the counter straight from a late latch write, so the interrupt would come early. A design that forgot to clear the pending flag after a direct load would reload on the next enable, so the interrupt would come late. The bench also fires strobes on line 240 and above and with rendering off; a loose line qualifier would count those lines and fire early. It lets the counter reach zero while disabled, which a broken enable gate would turn into a spurious interrupt. It forces a write and a strobe into the same cycle, where applying them in the wrong order changes whether the counter decrements or loads. Mirrored and unused addresses are mixed into a long pseudo-random phase, so a decoder that matches too many or too few addresses causes a mismatch against the model.

// File: rtl/scanline_irq_pkg.sv
`timescale 1ns/1ps
package scanline_irq_pkg;

   typedef enum logic [2:0] {
      CMD_NONE   = 3'd0,
      CMD_LATCH  = 3'd1,
      CMD_RELOAD = 3'd2,
      CMD_OFF    = 3'd3,
      CMD_ON     = 3'd4
   } slirq_cmd_e;

endpackage

// File: rtl/slirq_cmd_decode.sv
`timescale 1ns/1ps
module slirq_cmd_decode
   import scanline_irq_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter bit                MIRRORED   = 1'b1,
   parameter logic [ADDR_W-1:0] SEL_MASK   = 16'hE001,
   parameter logic [ADDR_W-1:0] LATCH_ADR  = 16'hC000,
   parameter logic [ADDR_W-1:0] RELOAD_ADR = 16'hC001,
   parameter logic [ADDR_W-1:0] OFF_ADR    = 16'hE000,
   parameter logic [ADDR_W-1:0] ON_ADR     = 16'hE001
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output slirq_cmd_e        cmd
);

   logic [ADDR_W-1:0] key;

   generate
      if (MIRRORED) begin : g_masked
         assign key = wr_addr & SEL_MASK;
      end else begin : g_exact
         assign key = wr_addr;
      end
   endgenerate

   always_comb begin
      cmd = CMD_NONE;
      if (wr_en) begin
         if (key == LATCH_ADR)       cmd = CMD_LATCH;
         else if (key == RELOAD_ADR) cmd = CMD_RELOAD;
         else if (key == OFF_ADR)    cmd = CMD_OFF;
         else if (key == ON_ADR)     cmd = CMD_ON;
      end
   end

endmodule

// File: rtl/slirq_line_qual.sv
`timescale 1ns/1ps
module slirq_line_qual #(
   parameter int LINE_W     = 9,
   parameter int FIRST_LINE = 0,
   parameter int LAST_LINE  = 239
) (
   input  logic              line_strobe,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   output logic              any_tick,
   output logic              count_tick
);

   localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(FIRST_LINE);
   localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(LAST_LINE);

   logic in_range;

   generate
      if (FIRST_LINE == 0) begin : g_from_zero
         assign in_range = (line_num <= LAST_L);
      end else begin : g_window
         assign in_range = (line_num >= FIRST_L) && (line_num <= LAST_L);
      end
   endgenerate

   assign any_tick   = line_strobe;
   assign count_tick = line_strobe & render_on & in_range;

endmodule

// File: rtl/slirq_core.sv
`timescale 1ns/1ps
module slirq_core
   import scanline_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slirq_cmd_e        cmd,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              any_tick,
   input  logic              count_tick,
   output logic              irq_o,
   output logic [DATA_W-1:0] count_o,
   output logic              enable_o,
   output logic              pending_o,
   output logic              direct_o
);

   localparam logic [DATA_W-1:0] ZERO = '0;
   localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

   logic [DATA_W-1:0] cnt_q, cnt_n, latch_q, latch_n;
   logic              en_q, en_n, pend_q, pend_n, dir_q, dir_n, irq_q, irq_n;

   always_comb begin
      cnt_n   = cnt_q;
      latch_n = latch_q;
      en_n    = en_q;
      pend_n  = pend_q;
      dir_n   = dir_q;
      irq_n   = irq_q;
      // strobe effect first
      if (any_tick) dir_n = 1'b0;
      if (count_tick && (cnt_q != ZERO)) begin
         cnt_n = cnt_q - ONE;
         if ((cnt_q == ONE) && en_q) irq_n = 1'b1;
      end
      // write effect on top
      case (cmd)
         CMD_LATCH: begin
            latch_n = wr_data;
            if (dir_n) begin
               cnt_n  = wr_data;
               pend_n = 1'b0;
            end else begin
               pend_n = 1'b1;
            end
         end
         CMD_RELOAD: cnt_n = latch_q;
         CMD_OFF: begin
            en_n  = 1'b0;
            irq_n = 1'b0;
            dir_n = 1'b1;
         end
         CMD_ON: begin
            en_n = 1'b1;
            if (pend_q) cnt_n = latch_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         latch_q <= '0;
         en_q    <= 1'b0;
         pend_q  <= 1'b0;
         dir_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         cnt_q   <= cnt_n;
         latch_q <= latch_n;
         en_q    <= en_n;
         pend_q  <= pend_n;
         dir_q   <= dir_n;
         irq_q   <= irq_n;
      end
   end

   assign irq_o     = irq_q;
   assign count_o   = cnt_q;
   assign enable_o  = en_q;
   assign pending_o = pend_q;
   assign direct_o  = dir_q;

endmodule

// File: rtl/scanline_irq_gen.sv
`timescale 1ns/1ps
module scanline_irq_gen
   import scanline_irq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int LINE_W     = 9,
   parameter int FIRST_LINE = 0,
   parameter int LAST_LINE  = 239,
   parameter bit MIRRORED   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_strobe,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   output logic              irq
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("scanline_irq_gen: DATA_W must be at least 1");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("scanline_irq_gen: ADDR_W must be at least 16");
      end
      if ((LAST_LINE >= (1 << LINE_W)) || (FIRST_LINE > LAST_LINE)) begin : g_bad_line
         $error("scanline_irq_gen: visible line window does not fit LINE_W");
      end
   endgenerate

   slirq_cmd_e        cmd;
   logic              any_tick, count_tick;
   logic [DATA_W-1:0] count_w;
   logic              enable_w, pending_w, direct_w;

   slirq_cmd_decode #(
      .ADDR_W     (ADDR_W),
      .MIRRORED   (MIRRORED),
      .SEL_MASK   (ADDR_W'(16'hE001)),
      .LATCH_ADR  (ADDR_W'(16'hC000)),
      .RELOAD_ADR (ADDR_W'(16'hC001)),
      .OFF_ADR    (ADDR_W'(16'hE000)),
      .ON_ADR     (ADDR_W'(16'hE001))
   ) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .cmd     (cmd)
   );

   slirq_line_qual #(
      .LINE_W     (LINE_W),
      .FIRST_LINE (FIRST_LINE),
      .LAST_LINE  (LAST_LINE)
   ) u_qual (
      .line_strobe (line_strobe),
      .line_num    (line_num),
      .render_on   (render_on),
      .any_tick    (any_tick),
      .count_tick  (count_tick)
   );

   slirq_core #(
      .DATA_W (DATA_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .wr_data    (wr_data),
      .any_tick   (any_tick),
      .count_tick (count_tick),
      .irq_o      (irq),
      .count_o    (count_w),
      .enable_o   (enable_w),
      .pending_o  (pending_w),
      .direct_o   (direct_w)
   );

endmodule

// File: rtl/scanline_irq_chk.sv
`timescale 1ns/1ps
module scanline_irq_chk
   import scanline_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input slirq_cmd_e        cmd,
   input logic              any_tick,
   input logic              count_tick,
   input logic [DATA_W-1:0] cnt,
   input logic              en,
   input logic              direct
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   // R1
   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !irq);

   // R5
   p_off_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_OFF) |=> (!irq && !en && direct));

   // R7
   p_zero_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) && (cmd == CMD_NONE) |=> (cnt == '0));

   // R7
   p_step_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count_tick && (cnt != '0) && (cmd == CMD_NONE) |=> (cnt == $past(cnt) - ONE));

   // R8
   p_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      count_tick && en && (cnt == ONE) && (cmd != CMD_OFF) |=> irq);

   // R8
   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && !(count_tick && en && (cnt == ONE)) |=> !irq);

   // R9
   p_direct_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      any_tick && (cmd != CMD_OFF) |=> !direct);

   // R10
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq && (cmd != CMD_OFF) |=> irq);

endmodule

bind scanline_irq_gen scanline_irq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .cmd        (cmd),
   .any_tick   (any_tick),
   .count_tick (count_tick),
   .cnt        (count_w),
   .en         (enable_w),
   .direct     (direct_w)
);

// File: tb/scanline_irq_gen_test.sv
`timescale 1ns/1ps
module scanline_irq_gen_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   logic        line_strobe;
   logic [8:0]  line_num;
   logic        render_on;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   string cur_req = "R1";

   // reference model state
   int m_cnt, m_latch, m_en, m_pend, m_dir, m_irq;

   always #10 clk = ~clk;

   scanline_irq_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .line_strobe(line_strobe), .line_num(line_num), .render_on(render_on), .irq(irq)
   );

   task automatic model_clear();
      m_cnt = 0; m_latch = 0; m_en = 0; m_pend = 0; m_dir = 0; m_irq = 0;
   endtask

   task automatic model_step(input bit w, input int a, input int d,
                             input bit s, input int ln, input bit r);
      if (s) begin
         m_dir = 0;
         if (ln <= 239 && r && m_cnt != 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0 && m_en != 0) m_irq = 1;
         end
      end
      if (w) begin
         case (a & 'hE001)
            'hC000: begin
               m_latch = d;
               if (m_dir != 0) begin m_cnt = d; m_pend = 0; end
               else m_pend = 1;
            end
            'hC001: m_cnt = m_latch;
            'hE000: begin m_en = 0; m_irq = 0; m_dir = 1; end
            'hE001: begin m_en = 1; if (m_pend != 0) m_cnt = m_latch; end
            default: ;
         endcase
      end
   endtask

   task automatic check_irq();
      n_checks++;
      if (irq !== m_irq[0]) begin
         n_fail++;
         $display("FAIL %s irq=%0b expected %0b at %0t", cur_req, irq, m_irq[0], $time);
      end
   endtask

   task automatic cyc(input bit w, input int a, input int d,
                      input bit s, input int ln, input bit r);
      @(negedge clk);
      wr_en = w; wr_addr = a[15:0]; wr_data = d[7:0];
      line_strobe = s; line_num = ln[8:0]; render_on = r;
      @(posedge clk);
      #1;
      model_step(w, a, d, s, ln, r);
      check_irq();
   endtask

   task automatic wr(input int a, input int d);
      cyc(1'b1, a, d, 1'b0, 0, 1'b1);
   endtask

   task automatic line(input int ln, input bit r);
      cyc(1'b0, 0, 0, 1'b1, ln, r);
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) begin
         line(i % 200, 1'b1);
         cyc(1'b0, 0, 0, 1'b0, 0, 1'b1);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 0; wr_addr = 0; wr_data = 0; line_strobe = 0; line_num = 0; render_on = 0;
      model_clear();
      repeat (2) @(negedge clk);
      #1;
      check_irq();
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0;
      wr_en = 0; wr_addr = 0; wr_data = 0; line_strobe = 0; line_num = 0; render_on = 0;
      model_clear();
      cur_req = "R1";
      do_reset();
      // enabled but counter zero: no interrupt
      wr('hE001, 0);
      lines(6);

      cur_req = "R2";
      wr('hE000, 0);
      line(10, 1'b1);           // clears direct-load
      wr('hC000, 3);           // latch only
      lines(4);                // counter still zero, no irq
      cur_req = "R6";
      wr('hE001, 0);           // pending -> counter = 3
      lines(3);                // fires on third

      cur_req = "R10";
      wr('hC001, 0);
      wr('hE001, 0);
      lines(5);
      cur_req = "R5";
      wr('hE000, 0);
      lines(1);

      cur_req = "R3";
      wr('hE000, 0);
      wr('hC000, 5);           // direct load, pending cleared
      wr('hE001, 0);           // no reload
      lines(5);
      wr('hE000, 0);
      wr('hC000, 4);
      lines(2);                // counter 2
      wr('hE001, 0);           // must not reload to 4
      lines(2);

      cur_req = "R4";
      wr('hE000, 0);
      line(20, 1'b1);
      wr('hC000, 2);
      wr('hE001, 0);
      lines(2);
      wr('hE000, 0);
      wr('hE001, 0);
      wr('hC001, 0);           // counter = 2 again
      lines(2);

      cur_req = "R9";
      wr('hE000, 0);
      line(300, 1'b0);         // any strobe clears direct-load
      wr('hC000, 6);           // latch only
      wr('hE001, 0);
      lines(6);

      cur_req = "R7";
      wr('hE000, 0);
      line(1, 1'b1);
      wr('hC000, 2);
      wr('hE001, 0);
      line(240, 1'b1);
      line(261, 1'b1);
      line(5, 1'b0);
      line(239, 1'b1);
      line(0, 1'b1);
      line(0, 1'b1);

      cur_req = "R8";
      wr('hE000, 0);
      wr('hC000, 2);           // direct, enable still clear
      lines(3);
      wr('hE001, 0);
      lines(3);

      cur_req = "R11";
      wr('hE000, 0);
      cyc(1'b1, 'hC000, 7, 1'b1, 3, 1'b1);   // strobe clears direct first: latch only
      wr('hE001, 0);
      cyc(1'b1, 'hC001, 0, 1'b1, 4, 1'b1);   // decrement then reload
      lines(6);
      wr('hE000, 0);
      wr('hC000, 1);
      wr('hE001, 0);
      cyc(1'b1, 'hE000, 0, 1'b1, 7, 1'b1);   // fire then cleared by disable
      lines(1);

      cur_req = "R12";
      wr('hE000, 0);
      line(2, 1'b1);
      wr('hDFFE, 3);           // mirror of latch
      wr('hFFFF, 0);           // mirror of enable
      wr('h8001, 9);
      wr('hA000, 1);
      wr('h6000, 9);
      wr('hC002, 3);
      lines(4);

      cur_req = "R1";
      wr('hE000, 0);
      wr('hC000, 1);
      wr('hE001, 0);
      lines(1);
      do_reset();
      wr('hE001, 0);
      lines(4);

      // mixed pseudo-random traffic
      cur_req = "R12";
      begin
         logic [15:0] lf;
         int addrs [8];
         int lns [5];
         addrs = '{'hC000, 'hC001, 'hE000, 'hE001, 'h8000, 'hA001, 'hDFFE, 'h6001};
         lns   = '{0, 100, 239, 240, 261};
         lf = 16'hACE1;
         for (int k = 0; k < 3000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0] & lf[1], addrs[lf[4:2]], int'(lf[7:5]),
                lf[8] | lf[9], lns[int'(lf[12:10]) % 5], lf[13] | lf[14]);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: actual hung, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule